// File: doc/BRIEF.md
# Grouped Cross-Coupled Multistate Memory Cell

This block is a memory cell built from inverting OR elements arranged in a number of groups of equal size. The output of every element is fed back to all elements outside its own group and to no element inside it. As a result, one group that holds any non-empty pattern of active outputs pushes every other group to zero. Each element also has two control inputs. One comes from a setting bus, which writes a chosen pattern into one group. The other comes from a saving bus, which decides which stored patterns the cell keeps while no setting is applied. With `GROUP_SIZE` elements per group, each group can hold 2^GROUP_SIZE − 1 distinct patterns.

The feedback loop is modelled as a registered network. Every element is a flip-flop, and each clock it loads the element function evaluated on the previous outputs. The cell reports four things: which group holds the state, whether exactly one group is active, whether the last update left the outputs unchanged, and whether the setting bus carries the word that clears everything and that no saving word can keep. A parent block drives a setting word long enough for the cell to establish it. It then removes the setting word and drives a saving word. Changing only the saving word can move the cell to a different pattern in the same group.

Top module: `gmc_cell`

## Requirements
- R1: While `rst_ni` is low, all element outputs, `valid_o` and `settled_o` are zero.
- R2: On each clock edge, a group whose setting bits are all 1 (active) loads all zeros.
- R3: A legal setting word is the bitwise inverse of a target pattern P. P is non-zero and lies inside one group g (bits g*GROUP_SIZE upward). Within two clock edges of applying it, `elem_o` equals P, whatever the previous state was.
- R4: `valid_o` is 1 exactly when one group has a non-zero pattern. `group_o` then gives that group's index.
- R5: With the setting bus all zero, a saving word keeps a stored pattern P in group g unchanged if it is 0 on P's active bits and 1 on the other bits of group g. Its bits in other groups can take any value.
- R6: When any setting bit is 1, the saving bus has no effect on the next state.
- R7: With the setting bus all zero and P stored in group g, a saving word S that is 1 on some of P's active bits but still 0 on at least one bit of group g moves the cell to the pattern (NOT S) restricted to group g, within one edge.
- R8: `settled_o` is 1 after an edge exactly when that edge left `elem_o` unchanged.
- R9: `forbidden_o` is 1 exactly when every setting bit is 1. That word leaves all elements at zero after the next edge, with `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Update clock of the registered loop |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | NUM_GROUPS*GROUP_SIZE | Setting bus, one bit per element, 1 = active |
| save_i | input | NUM_GROUPS*GROUP_SIZE | Saving bus, one bit per element, 1 = active |
| elem_o | output | NUM_GROUPS*GROUP_SIZE | Element outputs, group g at bits g*GROUP_SIZE upward |
| group_o | output | max(1,clog2(NUM_GROUPS)) | Index of the active group |
| valid_o | output | 1 | Exactly one group is non-zero |
| settled_o | output | 1 | The last update did not change the outputs |
| forbidden_o | output | 1 | Setting bus carries the clear-all word |

## Verification
The bench builds the cell with the default three groups of two elements. That makes the nine legal setting words and the forbidden one few enough to apply all of them, each starting from a state held in a different group or from the same group. At that size, every stored pattern can be tested against both a narrow and a wide saving word. Every full-group pattern can be tested against each single-bit disturbance that causes an in-group move. The unsettled, multi-group oscillation that follows reset with idle buses also becomes reachable.

// File: rtl/gmc_pkg.sv
package gmc_pkg;
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gmc_group.sv
module gmc_group #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_SIZE = 2,
  parameter int unsigned GRP        = 0,
  localparam int unsigned N = NUM_GROUPS * GROUP_SIZE
) (
  input  logic [N-1:0]          q_i,
  input  logic [N-1:0]          set_i,
  input  logic [N-1:0]          save_i,
  output logic [GROUP_SIZE-1:0] nxt_o
);
  logic [N-1:0] other_mask;
  logic         fb;

  for (genvar k = 0; k < N; k++) begin : g_mask
    assign other_mask[k] = ((k / GROUP_SIZE) != GRP);
  end

  // feedback only from foreign groups
  assign fb = |(q_i & other_mask);

  for (genvar e = 0; e < GROUP_SIZE; e++) begin : g_elem
    assign nxt_o[e] = ~(set_i[GRP*GROUP_SIZE+e] | save_i[GRP*GROUP_SIZE+e] | fb);
  end
endmodule

// File: rtl/gmc_decode.sv
module gmc_decode #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_SIZE = 2,
  localparam int unsigned N  = NUM_GROUPS * GROUP_SIZE,
  localparam int unsigned GW = gmc_pkg::idx_width(NUM_GROUPS)
) (
  input  logic [N-1:0]  q_i,
  output logic [GW-1:0] group_o,
  output logic          valid_o
);
  logic [NUM_GROUPS-1:0] nz;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_nz
    assign nz[g] = |q_i[g*GROUP_SIZE +: GROUP_SIZE];
  end

  assign valid_o = $onehot(nz);

  always_comb begin
    group_o = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (nz[g]) group_o = GW'(g);
    end
  end
endmodule

// File: rtl/gmc_cell.sv
module gmc_cell #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_SIZE = 2,
  localparam int unsigned N  = NUM_GROUPS * GROUP_SIZE,
  localparam int unsigned GW = gmc_pkg::idx_width(NUM_GROUPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  save_i,
  output logic [N-1:0]  elem_o,
  output logic [GW-1:0] group_o,
  output logic          valid_o,
  output logic          settled_o,
  output logic          forbidden_o
);
  logic [N-1:0] q_q, nxt, save_eff;
  logic         settled_q;

  // setting word absorbs the saving word
  assign save_eff = (|set_i) ? '0 : save_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gmc_group #(
      .NUM_GROUPS(NUM_GROUPS),
      .GROUP_SIZE(GROUP_SIZE),
      .GRP       (g)
    ) u_grp (
      .q_i   (q_q),
      .set_i (set_i),
      .save_i(save_eff),
      .nxt_o (nxt[g*GROUP_SIZE +: GROUP_SIZE])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q       <= '0;
      settled_q <= 1'b0;
    end else begin
      q_q       <= nxt;
      settled_q <= (nxt == q_q);
    end
  end

  gmc_decode #(
    .NUM_GROUPS(NUM_GROUPS),
    .GROUP_SIZE(GROUP_SIZE)
  ) u_dec (
    .q_i    (q_q),
    .group_o(group_o),
    .valid_o(valid_o)
  );

  assign elem_o      = q_q;
  assign settled_o   = settled_q;
  assign forbidden_o = &set_i;
endmodule

// File: rtl/gmc_checker.sv
module gmc_checker #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_SIZE = 2,
  localparam int unsigned N  = NUM_GROUPS * GROUP_SIZE,
  localparam int unsigned GW = gmc_pkg::idx_width(NUM_GROUPS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  set_i,
  input logic [N-1:0]  elem_o,
  input logic [GW-1:0] group_o,
  input logic          valid_o,
  input logic          settled_o,
  input logic          forbidden_o
);
  logic [N-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    for (int k = 0; k < N; k++) begin
      if ((k / GROUP_SIZE) == int'(group_o)) sel_mask[k] = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_clr
    AST_GROUP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&set_i[g*GROUP_SIZE +: GROUP_SIZE]) |=> (elem_o[g*GROUP_SIZE +: GROUP_SIZE] == '0)); // R2
  end

  AST_FORBID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forbidden_o |=> (elem_o == '0) && !valid_o); // R9

  AST_SETTLED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled_o |-> $stable(elem_o)); // R8

  AST_VALID_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((elem_o & sel_mask) != '0) && ((elem_o & ~sel_mask) == '0)); // R4
endmodule

bind gmc_cell gmc_checker #(
  .NUM_GROUPS(NUM_GROUPS),
  .GROUP_SIZE(GROUP_SIZE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .set_i      (set_i),
  .elem_o     (elem_o),
  .group_o    (group_o),
  .valid_o    (valid_o),
  .settled_o  (settled_o),
  .forbidden_o(forbidden_o)
);

// File: tb/sim_gmc_cell.sv
module sim_gmc_cell;
  localparam int NG = 3;
  localparam int GS = 2;
  localparam int N  = NG * GS;
  localparam int GW = gmc_pkg::idx_width(NG);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  set_i = '0;
  logic [N-1:0]  save_i = '0;
  logic [N-1:0]  elem_o;
  logic [GW-1:0] group_o;
  logic          valid_o, settled_o, forbidden_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  gmc_cell #(.NUM_GROUPS(NG), .GROUP_SIZE(GS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .set_i(set_i), .save_i(save_i),
    .elem_o(elem_o), .group_o(group_o), .valid_o(valid_o),
    .settled_o(settled_o), .forbidden_o(forbidden_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [N-1:0] gmask(int g);
    logic [N-1:0] m = '0;
    for (int e = 0; e < GS; e++) m[g*GS+e] = 1'b1;
    return m;
  endfunction

  function automatic logic [N-1:0] place(int g, int p);
    return N'(p) << (g * GS);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [N-1:0] exp_v;
    tick(2);
    chk(elem_o == '0, "R1 elem", int'(elem_o), 0);
    chk(!valid_o && !settled_o, "R1 flags", {valid_o, settled_o}, 0);
    rst_ni = 1'b1;
    tick(1);
    // idle buses from zero: every element rises, several groups active
    chk(elem_o == '1, "R4 multi elem", int'(elem_o), (1 << N) - 1);
    chk(!valid_o, "R4 multi valid", valid_o, 0);
    tick(2);
    chk(!settled_o, "R8 oscillating", settled_o, 0);

    for (int g = 0; g < NG; g++) begin
      for (int p = 1; p < (1 << GS); p++) begin
        exp_v  = place(g, p);
        set_i  = ~exp_v;
        save_i = (p % 2 == 1) ? '1 : '0;
        #1;
        chk(!forbidden_o, "R9 legal word", forbidden_o, 0);
        tick(1);
        chk((elem_o & ~gmask(g)) == '0, "R2 others cleared", int'(elem_o & ~gmask(g)), 0);
        tick(2);
        chk(elem_o == exp_v, (p % 2 == 1) ? "R6 absorbed save" : "R3 set", int'(elem_o), int'(exp_v));
        chk(valid_o && int'(group_o) == g, "R4 group", int'(group_o), g);
        chk(settled_o, "R8 settled after set", settled_o, 1);

        set_i  = '0;
        save_i = gmask(g) & ~exp_v;
        tick(3);
        chk(elem_o == exp_v, "R5 narrow save", int'(elem_o), int'(exp_v));
        chk(settled_o, "R8 settled on hold", settled_o, 1);
        save_i = ~exp_v;
        tick(3);
        chk(elem_o == exp_v, "R5 wide save", int'(elem_o), int'(exp_v));

        if (p == (1 << GS) - 1) begin
          for (int b = 0; b < GS; b++) begin
            set_i  = ~exp_v;
            save_i = '0;
            tick(3);
            set_i  = '0;
            save_i = place(g, 1 << b);
            tick(1);
            chk(elem_o == (exp_v & ~place(g, 1 << b)), "R7 moved",
                int'(elem_o), int'(exp_v & ~place(g, 1 << b)));
            chk(!settled_o, "R8 change edge", settled_o, 0);
            tick(1);
            chk(settled_o && valid_o && int'(group_o) == g, "R7 stable", int'(group_o), g);
          end
        end
      end
      if (g == 1) begin
        set_i  = '1;
        save_i = '0;
        #1;
        chk(forbidden_o, "R9 flag", forbidden_o, 1);
        tick(1);
        chk(elem_o == '0, "R9 cleared", int'(elem_o), 0);
        chk(!valid_o, "R9 not valid", valid_o, 0);
        set_i = '0;
      end
    end
    finish_run();
  end
endmodule